// File: doc/BRIEF.md
# Bidirectional Modulo Counter with Boundary Reload

This block is a 16-bit up/down position counter. It does not run over the full 0x0000 to 0xFFFF range. It circulates between a programmable lower and upper boundary. When the counter sits on the active boundary and takes one more step in the same direction, it is reloaded with the opposite boundary. A forward sweep therefore wraps from the top of the window to its bottom, and a backward sweep wraps from the bottom to its top.

Steps come from one of two sources, chosen by a static mode input:
- A quadrature decoder, which counts every edge of two phase signals (four counts per phase cycle).
- A count-pulse input together with a level-sensitive direction input.

All four external count inputs are synchronized through a two-flop chain before any decoding.

Software stages the boundaries through a small register write port. Each boundary has a live compare register and a preload register. The preload value is the one loaded into the counter on a wrap. Both compare registers are refreshed from their preloads whenever a boundary event happens, so a new window takes effect cleanly at a wrap.

The block reports the following outputs:
- The counter value.
- A one-cycle pulse for each boundary event, one per direction.
- The direction of the most recent step.
- A one-cycle error pulse for an illegal quadrature transition.

Top module: `bndWrapCounter`

## Requirements
- R1: After reset, the counter is 0, the upper compare and upper preload are 0xFFFF, the lower compare and lower preload are 0, `dirUp` is 1, and all pulse outputs are 0.
- R2: With `cntMode`=0, every change of exactly one synchronized phase bit is one step. The sequence {phaseA,phaseB} = 00, 01, 11, 10, 00 counts up, and the reverse sequence counts down.
- R3: With `cntMode`=0, a change of both phase bits between two synchronized samples leaves the counter unchanged and raises `quadErr` for exactly one cycle.
- R4: With `cntMode`=1, each rising edge of `cntIn` is one step: up when `dirIn`=1, down when `dirIn`=0. Falling edges of `cntIn`, changes of `dirIn` alone, and the phase inputs cause no step.
- R5: An input change made between clock edges shows on `count` after the third rising edge following it, and not earlier (two synchronizer flops plus one edge-detect flop).
- R6: An up step taken while the counter equals the upper compare loads the counter with the lower preload. In the same cycle as the new count, `cmpUpHit` is 1 for one cycle.
- R7: A down step taken while the counter equals the lower compare loads the counter with the upper preload. In the same cycle as the new count, `cmpDnHit` is 1 for one cycle.
- R8: The upper compare is evaluated only on up steps and the lower compare only on down steps. A down step at the upper compare decrements, and an up step at the lower compare increments, with no pulse.
- R9: Any other step adds or subtracts one and rolls through 0xFFFF/0x0000 in 16-bit arithmetic. The count never stops, whatever the compares hold.
- R10: On every boundary event (R6 or R7), both compare registers are loaded from their preload registers.
- R11: The write map is: address 0 counter, 1 upper compare, 2 upper preload, 3 lower compare, 4 lower preload; writes to 5 to 7 are ignored. A counter write in the same cycle as a step wins, the step is dropped, and no pulse is raised. A compare write wins over an R10 reload.
- R12: `dirUp` holds the direction of the most recent decoded step (1 = up) and stays unchanged while no step is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cntMode | input | 1 | 0 = quadrature source, 1 = count/direction source |
| phaseA | input | 1 | Quadrature phase A (asynchronous) |
| phaseB | input | 1 | Quadrature phase B (asynchronous) |
| cntIn | input | 1 | Count pulse, rising edge counts (asynchronous) |
| dirIn | input | 1 | Direction for count pulses, 1 = up (asynchronous) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register write address |
| regWrData | input | 16 | Register write data |
| count | output | 16 | Current counter value |
| cmpUpHit | output | 1 | Upper boundary event pulse |
| cmpDnHit | output | 1 | Lower boundary event pulse |
| dirUp | output | 1 | Direction of the latest step |
| quadErr | output | 1 | Illegal quadrature transition pulse |

## Verification
Two functions can fall in the same cycle:
- A counter write from the register port.
- A decoded step, including a step that would wrap at a boundary.

The bench provokes the collision by asserting the counter write exactly two falling edges after a phase change, so that the write is sampled on the same edge that applies the step. The behavioural model predicts that the written value survives, the step is dropped and no boundary pulse appears, and the count, pulses and direction are compared against that prediction on every cycle.

// File: rtl/bndCntPkg.sv
package bndCntPkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_COUNT  = 3'd0,
    ADDR_CMP_UP = 3'd1,
    ADDR_PRE_UP = 3'd2,
    ADDR_CMP_LO = 3'd3,
    ADDR_PRE_LO = 3'd4
  } regAddrE;

  // Strobes from control to datapath.
  typedef struct packed {
    logic stepEn;
    logic stepUp;
    logic wrCount;
    logic wrCmpUp;
    logic wrPreUp;
    logic wrCmpLo;
    logic wrPreLo;
  } ctrlStrobeT;

endpackage

// File: rtl/bndCntSync.sv
module bndCntSync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  genvar bitIdx;
  generate
    for (bitIdx = 0; bitIdx < WIDTH; bitIdx++) begin : gBit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din[bitIdx]};
      end
      assign dout[bitIdx] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/bndCntCtrl.sv
module bndCntCtrl
  import bndCntPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntMode,
  input  logic              phaseA,
  input  logic              phaseB,
  input  logic              cntIn,
  input  logic              dirIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobeT        strobes,
  output logic              quadErr
);

  logic [3:0] rawIn;
  logic [3:0] syncIn;   // {A, B, cnt, dir}
  logic [3:1] prevIn;

  assign rawIn = {phaseA, phaseB, cntIn, dirIn};

  bndCntSync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawIn),
    .dout (syncIn)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= syncIn[3:1];
  end

  logic aChg, bChg, quadStep, quadBad, quadUp, cntRise;

  always_comb begin
    aChg     = syncIn[3] ^ prevIn[3];
    bChg     = syncIn[2] ^ prevIn[2];
    quadStep = aChg ^ bChg;
    quadBad  = aChg & bChg;
    quadUp   = prevIn[3] ^ syncIn[2];
    cntRise  = syncIn[1] & ~prevIn[1];
  end

  always_comb begin
    strobes        = '0;
    strobes.stepEn = cntMode ? cntRise   : quadStep;
    strobes.stepUp = cntMode ? syncIn[0] : quadUp;
    if (regWrEn) begin
      case (regAddr)
        ADDR_COUNT:  strobes.wrCount = 1'b1;
        ADDR_CMP_UP: strobes.wrCmpUp = 1'b1;
        ADDR_PRE_UP: strobes.wrPreUp = 1'b1;
        ADDR_CMP_LO: strobes.wrCmpLo = 1'b1;
        ADDR_PRE_LO: strobes.wrPreLo = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) quadErr <= 1'b0;
    else       quadErr <= ~cntMode & quadBad;
  end

  // R2: a step is only decoded when some synchronized input moved
  assert_step_needs_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepEn |-> (syncIn[3:1] != prevIn));

  // R11: at most one register is written per cycle
  assert_one_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrCount, strobes.wrCmpUp, strobes.wrPreUp,
              strobes.wrCmpLo, strobes.wrPreLo}));

  // R3: an error pulse never comes with a step in quadrature mode
  assert_err_no_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(quadBad) && !cntMode) |-> !$past(strobes.stepEn));

endmodule

// File: rtl/bndCntData.sv
module bndCntData
  import bndCntPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobes,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             cmpUpHit,
  output logic             cmpDnHit,
  output logic             dirUp
);

  localparam logic [CNT_W-1:0] UP_RST = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LO_RST = '0;
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] cmpUp, preUp, cmpLo, preLo;
  logic upEvt, dnEvt, anyEvt;
  logic [CNT_W-1:0] countNext;

  always_comb begin
    upEvt  = strobes.stepEn &  strobes.stepUp & (count == cmpUp) & ~strobes.wrCount;
    dnEvt  = strobes.stepEn & ~strobes.stepUp & (count == cmpLo) & ~strobes.wrCount;
    anyEvt = upEvt | dnEvt;
    if (strobes.wrCount)     countNext = wrData;
    else if (upEvt)          countNext = preLo;
    else if (dnEvt)          countNext = preUp;
    else if (strobes.stepEn) countNext = strobes.stepUp ? count + ONE : count - ONE;
    else                     countNext = count;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      cmpUpHit <= 1'b0;
      cmpDnHit <= 1'b0;
      dirUp    <= 1'b1;
    end else begin
      count    <= countNext;
      cmpUpHit <= upEvt;
      cmpDnHit <= dnEvt;
      if (strobes.stepEn) dirUp <= strobes.stepUp;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpUp <= UP_RST;
      preUp <= UP_RST;
      cmpLo <= LO_RST;
      preLo <= LO_RST;
    end else begin
      if (strobes.wrPreUp) preUp <= wrData;
      if (strobes.wrPreLo) preLo <= wrData;
      if (strobes.wrCmpUp) cmpUp <= wrData;
      else if (anyEvt)     cmpUp <= preUp;
      if (strobes.wrCmpLo) cmpLo <= wrData;
      else if (anyEvt)     cmpLo <= preLo;
    end
  end

  // R6: an upper event leaves the counter at the former lower preload
  assert_up_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmpUpHit |-> (count == $past(preLo)));

  // R7: a lower event leaves the counter at the former upper preload
  assert_dn_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmpDnHit |-> (count == $past(preUp)));

  // R8: only one boundary is active per step
  assert_hits_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(cmpUpHit && cmpDnHit));

  // R9: a plain up step moves by one
  assert_unit_up_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.stepEn) && $past(strobes.stepUp) && !$past(strobes.wrCount) && !cmpUpHit)
      |-> (count == $past(count) + ONE));

  // R9: a plain down step moves by one
  assert_unit_dn_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.stepEn) && !$past(strobes.stepUp) && !$past(strobes.wrCount) && !cmpDnHit)
      |-> (count == $past(count) - ONE));

  // R12: direction holds without a step
  assert_dir_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.stepEn |=> $stable(dirUp));

endmodule

// File: rtl/bndWrapCounter.sv
module bndWrapCounter
  import bndCntPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntMode,
  input  logic              phaseA,
  input  logic              phaseB,
  input  logic              cntIn,
  input  logic              dirIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  count,
  output logic              cmpUpHit,
  output logic              cmpDnHit,
  output logic              dirUp,
  output logic              quadErr
);

  ctrlStrobeT strobes;

  bndCntCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cntMode (cntMode),
    .phaseA  (phaseA),
    .phaseB  (phaseB),
    .cntIn   (cntIn),
    .dirIn   (dirIn),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes),
    .quadErr (quadErr)
  );

  bndCntData #(.CNT_W(CNT_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (regWrData),
    .count    (count),
    .cmpUpHit (cmpUpHit),
    .cmpDnHit (cmpDnHit),
    .dirUp    (dirUp)
  );

endmodule

// File: tb/bndWrapCounter_tb_top.sv
`timescale 1ns/1ps
module bndWrapCounter_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntMode = 1'b0, phaseA = 1'b0, phaseB = 1'b0, cntIn = 1'b0, dirIn = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] count;
  logic cmpUpHit, cmpDnHit, dirUp, quadErr;

  always #10 clk = ~clk;  // 50 MHz

  bndWrapCounter dut_i (
    .clk(clk), .rstN(rstN), .cntMode(cntMode), .phaseA(phaseA), .phaseB(phaseB),
    .cntIn(cntIn), .dirIn(dirIn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .count(count), .cmpUpHit(cmpUpHit),
    .cmpDnHit(cmpDnHit), .dirUp(dirUp), .quadErr(quadErr)
  );

  int nChecks = 0;
  int nFails  = 0;
  string curReq = "R1";
  bit armed = 1'b0;

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mCount, mCmpUp, mPreUp, mCmpLo, mPreLo;
  bit mDir, mUpHit, mDnHit, mErr;
  logic [3:0] hist [0:3];

  function automatic int quadPos(logic a, logic b);
    case ({a, b})
      2'b00:   return 0;
      2'b01:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 0; mCmpUp = 16'hFFFF; mPreUp = 16'hFFFF; mCmpLo = 0; mPreLo = 0;
      mDir = 1; mUpHit = 0; mDnHit = 0; mErr = 0;
      for (int i = 0; i < 4; i++) hist[i] = '0;
    end else begin
      bit step, up, evt;
      int delta;
      for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = {phaseA, phaseB, cntIn, dirIn};
      step = 0; up = 0; mErr = 0;
      if (cntMode) begin
        step = hist[2][1] && !hist[3][1];
        up   = hist[2][0];
      end else begin
        delta = (quadPos(hist[2][3], hist[2][2]) - quadPos(hist[3][3], hist[3][2]) + 4) % 4;
        step = (delta == 1) || (delta == 3);
        up   = (delta == 1);
        mErr = (delta == 2);
      end
      mUpHit = 0; mDnHit = 0;
      if (step) mDir = up;
      if (step && !(regWrEn && regAddr == 3'd0)) begin
        if (up && mCount == mCmpUp)       begin mCount = mPreLo; mUpHit = 1; end
        else if (!up && mCount == mCmpLo) begin mCount = mPreUp; mDnHit = 1; end
        else mCount = up ? (mCount + 1) & 16'hFFFF : (mCount + 16'hFFFF) & 16'hFFFF;
      end
      evt = mUpHit || mDnHit;
      if (evt) begin mCmpUp = mPreUp; mCmpLo = mPreLo; end
      if (regWrEn) begin
        case (regAddr)
          3'd0: mCount = regWrData;
          3'd1: mCmpUp = regWrData;
          3'd2: mPreUp = regWrData;
          3'd3: mCmpLo = regWrData;
          3'd4: mPreLo = regWrData;
          default: ;
        endcase
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && armed) begin
      chk({curReq, " count"},  count,    mCount);
      chk({curReq, " upHit"},  cmpUpHit, mUpHit);
      chk({curReq, " dnHit"},  cmpDnHit, mDnHit);
      chk({curReq, " dirUp"},  dirUp,    mDir);
      chk({curReq, " quadErr"}, quadErr, mErr);
    end
  end

  // ---------------- stimulus helpers ----------------
  int qpos = 0;

  task automatic wr(int a, int d);
    @(negedge clk); regWrEn = 1; regAddr = a[2:0]; regWrData = d[15:0];
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic setPos(int p);
    qpos = p;
    case (p)
      0: {phaseA, phaseB} = 2'b00;
      1: {phaseA, phaseB} = 2'b01;
      2: {phaseA, phaseB} = 2'b11;
      default: {phaseA, phaseB} = 2'b10;
    endcase
  endtask

  // one quadrature step; returns at the falling edge where the result is visible
  task automatic qStep(bit up);
    @(negedge clk); setPos((qpos + (up ? 1 : 3)) % 4);
    repeat (3) @(negedge clk);
  endtask

  task automatic cPulse(bit up);
    @(negedge clk); dirIn = up; cntIn = 1;
    repeat (3) @(negedge clk); cntIn = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    int exp;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    armed = 1;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 upHit", cmpUpHit, 0);
    chk("R1 dnHit", cmpDnHit, 0);
    chk("R1 dirUp", dirUp, 1);
    chk("R1 quadErr", quadErr, 0);
    // R1/R7: lower boundary 0 at reset, upper preload 0xFFFF
    curReq = "R7";
    qStep(0);
    chk("R7 wrap to upper preload", count, 16'hFFFF);
    chk("R7 dnHit pulse", cmpDnHit, 1);
    chk("R12 dir down", dirUp, 0);
    curReq = "R6";
    qStep(1);
    chk("R6 wrap to lower preload", count, 0);
    chk("R6 upHit pulse", cmpUpHit, 1);

    // R5 latency
    curReq = "R5";
    @(negedge clk); setPos(1);
    @(negedge clk); chk("R5 after 1 edge", count, 0);
    @(negedge clk); chk("R5 after 2 edges", count, 0);
    @(negedge clk); chk("R5 after 3 edges", count, 1);

    // program window 10..20
    curReq = "R11";
    wr(4, 10); wr(3, 10); wr(2, 20); wr(1, 20); wr(0, 15);
    chk("R11 counter write", count, 15);

    // R2/R6 forward sweep
    curReq = "R2";
    exp = 15;
    for (int i = 0; i < 8; i++) begin
      exp = (exp == 20) ? 10 : exp + 1;
      qStep(1);
      chk("R2 forward sweep", count, exp);
    end
    chk("R6 after forward wrap", count, 12);

    // R2/R7 backward sweep
    curReq = "R7";
    for (int i = 0; i < 6; i++) begin
      exp = (exp == 10) ? 20 : exp - 1;
      qStep(0);
      chk("R7 backward sweep", count, exp);
    end
    chk("R7 after backward wrap", count, 17);

    // R8 direction-selected compare
    curReq = "R8";
    wr(0, 20); qStep(0);
    chk("R8 down at upper compare", count, 19);
    chk("R8 no dnHit", cmpDnHit, 0);
    wr(0, 10); qStep(1);
    chk("R8 up at lower compare", count, 11);
    chk("R8 no upHit", cmpUpHit, 0);

    // R3 illegal double transition
    curReq = "R3";
    @(negedge clk); setPos((qpos + 2) % 4);
    repeat (3) @(negedge clk);
    chk("R3 count held", count, 11);
    chk("R3 error pulse", quadErr, 1);
    @(negedge clk);
    chk("R3 error one cycle", quadErr, 0);

    // R9 roll through 16-bit ends outside window
    curReq = "R9";
    wr(0, 0); qStep(0);
    chk("R9 roll under", count, 16'hFFFF);
    qStep(1);
    chk("R9 roll over", count, 0);

    // R10 compare reload on boundary event
    curReq = "R10";
    wr(2, 25); wr(0, 19);
    qStep(1); chk("R10 step to old upper", count, 20);
    qStep(1); chk("R10 wrap at old upper", count, 10);
    wr(0, 24);
    qStep(1); chk("R10 new upper in use", count, 25);
    qStep(1); chk("R10 wrap at new upper", count, 10);

    // R11 collision of counter write and step
    curReq = "R11";
    wr(0, 25);
    @(negedge clk); setPos((qpos + 1) % 4);
    @(negedge clk);
    @(negedge clk); regWrEn = 1; regAddr = 3'd0; regWrData = 16'd100;
    @(negedge clk); regWrEn = 0;
    chk("R11 write beats step", count, 100);
    chk("R11 no pulse on collision", cmpUpHit, 0);
    repeat (3) @(negedge clk);
    chk("R11 step dropped", count, 100);
    wr(6, 16'h1234);
    chk("R11 unmapped address ignored", count, 100);

    // R4 count/direction mode
    curReq = "R4";
    cntMode = 1;
    wr(0, 15);
    cPulse(1); chk("R4 up pulse", count, 16);
    cPulse(0); chk("R4 down pulse", count, 15);
    chk("R12 dir after down pulse", dirUp, 0);
    @(negedge clk); dirIn = 1; phaseA = ~phaseA;
    repeat (5) @(negedge clk);
    chk("R4 dir and phase ignored", count, 15);
    chk("R12 dir held", dirUp, 0);
    wr(0, 25);
    cPulse(1); chk("R4 wrap in count mode", count, 10);
    cPulse(0); chk("R4 down wrap in count mode", count, 25);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule